// File: doc/BRIEF.md
# Serial Read-Only Memory Slave

This block is the slave side of a four-wire serial memory port for a byte-wide read-only array. A host lowers the select line and clocks in a one-byte opcode, MSB first. Three opcodes are understood. A plain read takes a three-byte address and then streams array bytes. A fast read takes the same address followed by one throw-away byte before data. An identification read returns a fixed three-byte signature. Data keeps streaming for as long as the host keeps clocking and the select line stays low. The streaming address steps by one after each byte and wraps at the top of the array.

All three serial pins are sampled by the block's own system clock through a short synchronizer, and the serial clock edges are recovered from the sampled value. Input bits are taken on the rising edge of the serial clock. The output bit and its enable change after a falling edge. The array is a pure function of the address, so every byte it returns is predictable. An opcode the block does not know puts it into a standby state for the rest of the frame. In standby the output enable stays low and further clocks have no effect. Raising the select line always returns the block to the opcode-wait state.

Top module: `srom_serial_rom`

## Requirements
- R1: After reset, and from `SYNC_STAGES+2` clock cycles after `cs_n` rises, `so_en` and `so_data` are both 0.
- R2: Opcode 0x03 is followed by three address bytes. In the first address byte, bits 5..0 are A21..A16 and bits 7..6 are ignored. The second byte is A15..A8 and the third is A7..A0. Address bits at and above `ADDR_W` are ignored. The first data bit is driven after the falling serial clock edge that follows the last address bit.
- R3: Opcode 0x0B takes the same three address bytes and then one dummy byte whose value has no effect. Data starts after the falling edge that follows the last dummy bit.
- R4: Opcode 0x9F returns the bytes 0xAE, 0x41, 0x14 in that order. From the falling edge after the last bit of 0x14, `so_en` is 0 for the rest of the frame.
- R5: Every byte, in and out, is shifted MSB first. Input bits are taken at rising serial clock edges and output bits change at falling edges.
- R6: While streaming, the address advances by one per byte and wraps from 2^ADDR_W-1 to 0.
- R7: Any other opcode puts the block in standby. `so_en` stays 0 and later bytes are ignored, even valid opcodes, until `cs_n` rises.
- R8: Raising `cs_n` mid-frame abandons the frame. The next frame decodes its first byte as a fresh opcode.
- R9: `so_en` is 0 during the opcode, address and dummy bytes. `so_data` and `so_en` change only in the cycle after a recovered falling edge, or when select goes inactive.
- R10: The byte stored at address a is ((a[7:0]*29 + a[15:8] + a[23:16]) mod 256) XOR 0x5A, where a is zero-extended to 24 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so_data | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable; 0 means the pin is high-impedance |

## Verification
An input bit on `si` takes effect `SYNC_STAGES+1` clock cycles after the rising serial edge. A change of `so_data` or `so_en` lands `SYNC_STAGES+1` cycles after the falling serial edge that caused it. The bench holds each serial clock phase for eight system cycles. It compares the output with its own model on the seventh cycle of every low phase, when the latest change has long settled and the next rising edge has not yet been seen. Select-release checks wait eight cycles after `cs_n` rises, which is well past the synchronizer delay.

// File: rtl/srom_pkg.sv
// Package: opcodes, identification bytes and controller states shared by the
// serial ROM slave. Assumes byte-wide transfers, MSB first.
package srom_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_IDENT = 8'h9F;

    localparam logic [7:0] ID_MAKER = 8'hAE;
    localparam logic [7:0] ID_KIND  = 8'h41;
    localparam logic [7:0] ID_SIZE  = 8'h14;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_LOAD,
        ST_DATA,
        ST_ID,
        ST_DRAIN,
        ST_STANDBY
    } srom_state_e;

    // Identification byte for a given position; zero past the end.
    function automatic logic [7:0] id_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    id_byte = ID_MAKER;
            2'd1:    id_byte = ID_KIND;
            2'd2:    id_byte = ID_SIZE;
            default: id_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/srom_sync.sv
// Multi-bit flop chain that brings asynchronous pins into the clk domain.
// Assumes each bit is sampled independently; the pins are slow compared with clk.
module srom_sync #(
    parameter int         W          = 3,
    parameter int         STAGES     = 2,
    parameter logic [W-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the pins through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/srom_edge.sv
// Recovers one-cycle rise and fall pulses from a synchronized level.
// Assumes the level is already in the clk domain.
module srom_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic prev;

    // Remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

endmodule

// File: rtl/srom_pattern.sv
// Read-only array modelled as a fixed function of the address, so that no
// storage is needed and every byte is predictable. Assumes ADDR_W <= 22.
module srom_pattern #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);

    logic [23:0] a_ext;
    logic [15:0] prod;

    // Mix the three address bytes into one data byte.
    always_comb begin
        a_ext = 24'(addr);
        prod  = 16'(a_ext[7:0]) * 16'd29;
        data  = (prod[7:0] + a_ext[15:8] + a_ext[23:16]) ^ 8'h5A;
    end

endmodule

// File: rtl/srom_engine.sv
// Command engine: gathers input bytes on recovered rising edges, decodes the
// opcode, captures the address, skips the dummy byte and shifts bytes out on
// recovered falling edges. Assumes rise and fall pulses never coincide and that
// at least two clk cycles separate consecutive serial edges.
module srom_engine
    import srom_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_idle,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              si_bit,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        arr_data,
    output logic              so_data,
    output logic              so_en,
    output logic              in_standby
);

    srom_state_e       state;
    logic [7:0]        in_sr;
    logic [2:0]        in_cnt;
    logic [1:0]        hdr_cnt;
    logic              fast;
    logic [15:0]       addr_sh;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        out_sr;
    logic [2:0]        out_cnt;
    logic [1:0]        id_idx;

    logic [7:0]        nxt_byte;
    logic [23:0]       addr_full;
    logic              addr_unused;

    assign nxt_byte    = {in_sr[6:0], si_bit};
    assign addr_full   = {addr_sh, nxt_byte};
    assign addr_unused = ^addr_full[23:ADDR_W];
    assign arr_addr    = rd_addr;
    assign in_standby  = (state == ST_STANDBY);

    // Frame state machine with input and output shifters.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_idle) begin
            state   <= ST_CMD;
            in_sr   <= '0;
            in_cnt  <= '0;
            hdr_cnt <= '0;
            fast    <= 1'b0;
            addr_sh <= '0;
            rd_addr <= '0;
            out_sr  <= '0;
            out_cnt <= '0;
            id_idx  <= '0;
            so_data <= 1'b0;
            so_en   <= 1'b0;
        end else begin
            if (state == ST_LOAD) begin
                out_sr  <= arr_data;
                rd_addr <= rd_addr + 1'b1;
                out_cnt <= '0;
                state   <= ST_DATA;
            end

            if (sclk_rise) begin
                in_sr  <= nxt_byte;
                in_cnt <= in_cnt + 3'd1;
                if (in_cnt == 3'd7) begin
                    case (state)
                        ST_CMD: begin
                            hdr_cnt <= '0;
                            if (nxt_byte == OP_READ) begin
                                fast  <= 1'b0;
                                state <= ST_ADDR;
                            end else if (nxt_byte == OP_FAST) begin
                                fast  <= 1'b1;
                                state <= ST_ADDR;
                            end else if (nxt_byte == OP_IDENT) begin
                                out_sr  <= id_byte(2'd0);
                                out_cnt <= '0;
                                id_idx  <= '0;
                                state   <= ST_ID;
                            end else begin
                                state <= ST_STANDBY;
                            end
                        end
                        ST_ADDR: begin
                            addr_sh <= addr_full[15:0];
                            hdr_cnt <= hdr_cnt + 2'd1;
                            if (hdr_cnt == 2'd2) begin
                                rd_addr <= addr_full[ADDR_W-1:0];
                                state   <= fast ? ST_DUMMY : ST_LOAD;
                            end
                        end
                        ST_DUMMY: state <= ST_LOAD;
                        default: ;
                    endcase
                end
            end

            if (sclk_fall) begin
                case (state)
                    ST_DATA, ST_ID: begin
                        so_en   <= 1'b1;
                        so_data <= out_sr[7];
                        out_sr  <= {out_sr[6:0], 1'b0};
                        out_cnt <= out_cnt + 3'd1;
                        if (out_cnt == 3'd7) begin
                            if (state == ST_DATA) begin
                                out_sr  <= arr_data;
                                rd_addr <= rd_addr + 1'b1;
                            end else begin
                                id_idx <= id_idx + 2'd1;
                                out_sr <= id_byte(id_idx + 2'd1);
                                if (id_idx == 2'd2) state <= ST_DRAIN;
                            end
                        end
                    end
                    ST_DRAIN: begin
                        so_en   <= 1'b0;
                        so_data <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/srom_serial_rom.sv
// Top of the serial ROM slave: synchronizes the pins, recovers serial clock
// edges and connects the command engine to the pattern array. Assumes clk runs
// several times faster than sclk.
module srom_serial_rom #(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic si,
    output logic so_data,
    output logic so_en
);

    logic [2:0]        pins_s;
    logic              cs_idle;
    logic              sclk_s;
    logic              si_s;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              in_standby;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_data;

    srom_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, si}), .q(pins_s)
    );

    assign cs_idle = pins_s[2];
    assign sclk_s  = pins_s[1];
    assign si_s    = pins_s[0];

    srom_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise(sclk_rise), .fall(sclk_fall)
    );

    srom_pattern #(.ADDR_W(ADDR_W)) u_array (
        .addr(arr_addr), .data(arr_data)
    );

    srom_engine #(.ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .si_bit(si_s),
        .arr_addr(arr_addr), .arr_data(arr_data),
        .so_data(so_data), .so_en(so_en), .in_standby(in_standby)
    );

endmodule

// File: rtl/srom_checks.sv
// Checker bound to the top: output timing, select release and standby rules.
module srom_checks (
    input logic clk,
    input logic rst_n,
    input logic cs_idle,
    input logic sclk_fall,
    input logic in_standby,
    input logic so_data,
    input logic so_en
);

    // R1: a deselected frame leaves the output disabled.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle |=> !so_en);

    // R9: output data moves only after a recovered falling edge or release.
    a_r9_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so_data) |-> ($past(sclk_fall) || $past(cs_idle)));

    // R9: output enable turns on only after a recovered falling edge.
    a_r9_en_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_en) |-> $past(sclk_fall));

    // R7: standby holds until select is released.
    a_r7_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && !cs_idle) |=> (in_standby || cs_idle));

    // R7: nothing is driven in standby.
    a_r7_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
        in_standby |-> !so_en);

endmodule

bind srom_serial_rom srom_checks u_chk (
    .clk(clk), .rst_n(rst_n), .cs_idle(cs_idle), .sclk_fall(sclk_fall),
    .in_standby(in_standby), .so_data(so_data), .so_en(so_en)
);

// File: tb/srom_serial_rom_bench.sv
module srom_serial_rom_bench;

    localparam int ADDR_W = 12;
    localparam int AMASK  = (1 << ADDR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic si = 1'b0;
    logic so_data;
    logic so_en;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef logic [7:0] bq_t[$];

    always #10 clk = ~clk;

    srom_serial_rom #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_srom_serial_rom (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si),
        .so_data(so_data), .so_en(so_en)
    );

    // R10 array model
    function automatic logic [7:0] pat(input int a);
        int lo, mid, hi;
        lo  = a & 255;
        mid = (a >> 8) & 255;
        hi  = (a >> 16) & 255;
        return 8'((lo * 29 + mid + hi) & 255) ^ 8'h5A;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, so_en, 1'b0);
        check(req, so_data, 1'b0);
    endtask

    // Drives one frame; compares the output at every bit against the model.
    task automatic run_frame(input bq_t hdr, input bq_t expq, input int extra,
                             input string req);
        int nin, nout, total;
        nin   = 8 * hdr.size();
        nout  = 8 * expq.size();
        total = nin + nout + extra;
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < total; b++) begin
            if (b < nin) si = hdr[b / 8][7 - (b % 8)];
            else         si = b[0];
            repeat (7) @(negedge clk);
            if (b < nin) begin
                check("R9", so_en, 1'b0);
            end else if (b < nin + nout) begin
                check(req, so_en, 1'b1);
                check(req, so_data, expq[(b - nin) / 8][7 - ((b - nin) % 8)]);
            end else begin
                check(req, so_en, 1'b0);
            end
            @(negedge clk) sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check_idle("R1");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        bq_t h, e;
        repeat (4) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check_idle("R1");

        // R2 R5 R10: plain read from 0x010
        h = '{8'h03, 8'h00, 8'h00, 8'h10};
        e = {};
        for (int i = 0; i < 4; i++) e.push_back(pat(16 + i));
        run_frame(h, e, 0, "R2");

        // R6: upper address bits ignored, wrap at the top
        h = '{8'h03, 8'hFF, 8'h0F, 8'hFE};
        e = {};
        for (int i = 0; i < 5; i++) e.push_back(pat((12'hFFE + i) & AMASK));
        run_frame(h, e, 0, "R6");

        // R3: fast read, dummy 0xA5
        h = '{8'h0B, 8'h00, 8'h01, 8'h23};
        h.push_back(8'hA5);
        e = {};
        for (int i = 0; i < 3; i++) e.push_back(pat(12'h123 + i));
        run_frame(h, e, 0, "R3");

        // R3: dummy that looks like an opcode has no effect
        h = '{8'h0B, 8'h00, 8'h07, 8'h80};
        h.push_back(8'h03);
        e = {};
        for (int i = 0; i < 2; i++) e.push_back(pat(12'h780 + i));
        run_frame(h, e, 0, "R3");

        // R4 R5: identification, then silence
        h = '{8'h9F};
        e = '{8'hAE, 8'h41, 8'h14};
        run_frame(h, e, 16, "R4");

        // R7: unknown opcode, then a valid read frame body is ignored
        h = '{8'h05, 8'h03, 8'h00, 8'h00};
        h.push_back(8'h00);
        e = {};
        run_frame(h, e, 16, "R7");

        // R8: abort after 12 bits
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int b = 0; b < 12; b++) begin
            si = (b < 8) ? 8'h03 >> (7 - b) : 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
        check_idle("R8");

        // R8: next frame decodes a fresh opcode
        h = '{8'h03, 8'h00, 8'h00, 8'h42};
        e = '{pat(12'h042), pat(12'h043)};
        run_frame(h, e, 0, "R8");

        // R8: and identification after it
        h = '{8'h9F};
        e = '{8'hAE, 8'h41, 8'h14};
        run_frame(h, e, 0, "R8");

        done = 1'b1;
        finish_run();
    end

endmodule